// File: doc/BRIEF.md
# Dual-Rail Precharge Codec

This block sits on both sides of a datapath that signals in two phases on paired wires. On the way in, it turns two single-rail operands into true and complement rails. During the precharge phase every rail is held low. During the evaluate phase the true rail carries the data bit and the complement rail carries its inverse. From the same rails it derives a one-hot generate, propagate or kill code for every operand bit pair. That code is silent in precharge. The kill line is the generate term taken on the complement rails, so a single encoder supplies both polarities of generate.

On the way out, it watches a word of dual-rail result pairs. On each clock it registers the decoded value, a valid flag and a sticky error flag. The valid flag is set only in the evaluate phase, and only when every pair holds exactly one high rail. The error flag catches the forbidden pair code in which both rails are high, in either phase. It also catches any pair that is not idle during precharge. The flag stays set until a synchronous reset. Only the logical codes and the phase sequencing are modelled. Electrical effects are not.

Top module: `dualrail_codec`

## Requirements
- R1: While `eval_phase` is 0, all four operand rail buses (`a_t`, `a_f`, `b_t`, `b_f`) are 0 in the same cycle (pair code 00 = precharge).
- R2: While `eval_phase` is 1, `a_t` equals `op_a` and `a_f` equals its bitwise inverse, and likewise for `b_t`/`b_f` with `op_b` (pair code true,comp = 01 means 0, 10 means 1), combinationally.
- R3: While `eval_phase` is 1, for every bit i exactly one of `gen[i]`, `prop[i]` and `kill[i]` is 1. `gen` = a AND b, `prop` = a XOR b, and `kill` = (NOT a) AND (NOT b), the last taken as the AND of the complement rails.
- R4: While `eval_phase` is 0, `gen`, `prop` and `kill` are all 0.
- R5: On a clock edge where `eval_phase` is 1 and every result pair (`res_t[i]`,`res_f[i]`) is 01 or 10, `res_valid` becomes 1 and `res_value` becomes `res_t` after that edge. Otherwise `res_valid` becomes 0.
- R6: On an edge that does not meet the R5 condition, `res_value` keeps its previous value.
- R7: A result pair equal to 11 at a clock edge, in either phase, sets `res_err` after that edge.
- R8: A result pair other than 00 at an edge where `eval_phase` is 0 sets `res_err` after that edge.
- R9: `res_err` stays 1 until an edge with `rst` = 1. Such an edge clears `res_value`, `res_valid` and `res_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_phase | input | 1 | 1 = evaluate phase, 0 = precharge phase |
| op_a | input | W | Single-rail operand A |
| op_b | input | W | Single-rail operand B |
| a_t | output | W | Operand A true rails |
| a_f | output | W | Operand A complement rails |
| b_t | output | W | Operand B true rails |
| b_f | output | W | Operand B complement rails |
| gen | output | W | Per-bit generate (one-hot group) |
| prop | output | W | Per-bit propagate (one-hot group) |
| kill | output | W | Per-bit kill (one-hot group) |
| res_t | input | W | Result true rails |
| res_f | input | W | Result complement rails |
| res_value | output | W | Registered decoded result |
| res_valid | output | 1 | Registered: last edge saw a complete legal evaluate word |
| res_err | output | 1 | Sticky protocol error flag |

## Verification
Random operand pairs are driven in alternating precharge and evaluate cycles. This separates a rail that leaks data in precharge from one that fails to invert in evaluate, and random bit pairs cover all four generate/propagate/kill cases. Result words are driven as fully legal codes, as words with a single idle pair (incomplete), as 11 injections in each phase, and as stray non-idle pairs in precharge. These patterns tell valid-gating apart from value holding. They also check error stickiness across clean cycles and its clearing by reset.

// File: rtl/dualrail_pkg.sv
package dualrail_pkg;

    // Pair code written as {true_rail, complement_rail}
    typedef enum logic [1:0] {
        PAIR_IDLE = 2'b00,
        PAIR_ZERO = 2'b01,
        PAIR_ONE  = 2'b10,
        PAIR_BAD  = 2'b11
    } pair_code_e;

    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } gpk_t;

    function automatic pair_code_e pair_code(input logic t, input logic f);
        return pair_code_e'({t, f});
    endfunction

    // Derived from rails only: idle rails give an all-zero code
    function automatic gpk_t gpk_from_rails(input logic at, input logic af,
                                            input logic bt, input logic bf);
        gpk_t c;
        c.gen  = at & bt;
        c.kill = af & bf;
        c.prop = (at & bf) | (af & bt);
        return c;
    endfunction

endpackage

// File: rtl/rail_encoder.sv
module rail_encoder #(
    parameter int W = 8
) (
    input  logic         phase,
    input  logic [W-1:0] data,
    output logic [W-1:0] rail_t,
    output logic [W-1:0] rail_f
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            rail_t[i] = phase &  data[i];
            rail_f[i] = phase & ~data[i];
        end
    end
endmodule

// File: rtl/gpk_encoder.sv
module gpk_encoder
    import dualrail_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] at,
    input  logic [W-1:0] af,
    input  logic [W-1:0] bt,
    input  logic [W-1:0] bf,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] kill
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        gpk_t code;
        always_comb begin
            code    = gpk_from_rails(at[i], af[i], bt[i], bf[i]);
            gen[i]  = code.gen;
            prop[i] = code.prop;
            kill[i] = code.kill;
        end
    end
endmodule

// File: rtl/rail_decoder.sv
module rail_decoder
    import dualrail_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         phase,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic [W-1:0] value,
    output logic         valid,
    output logic         err
);
    logic [W-1:0] pair_legal;
    logic [W-1:0] pair_bad;
    logic [W-1:0] pair_busy;

    for (genvar i = 0; i < W; i++) begin : g_pair
        pair_code_e pc;
        always_comb begin
            pc           = pair_code(rail_t[i], rail_f[i]);
            pair_legal[i] = (pc == PAIR_ZERO) || (pc == PAIR_ONE);
            pair_bad[i]   = (pc == PAIR_BAD);
            pair_busy[i]  = (pc != PAIR_IDLE);
        end
    end

    logic word_ok;
    logic fault;
    always_comb begin
        word_ok = phase && (&pair_legal);
        fault   = (|pair_bad) || (!phase && (|pair_busy));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            valid <= 1'b0;
            err   <= 1'b0;
        end else begin
            valid <= word_ok;
            if (word_ok) value <= rail_t;
            if (fault)   err   <= 1'b1;
        end
    end
endmodule

// File: rtl/dualrail_codec.sv
module dualrail_codec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         eval_phase,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] a_t,
    output logic [W-1:0] a_f,
    output logic [W-1:0] b_t,
    output logic [W-1:0] b_f,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] kill,
    input  logic [W-1:0] res_t,
    input  logic [W-1:0] res_f,
    output logic [W-1:0] res_value,
    output logic         res_valid,
    output logic         res_err
);
    rail_encoder #(.W(W)) u_enc_a (
        .phase(eval_phase), .data(op_a), .rail_t(a_t), .rail_f(a_f)
    );
    rail_encoder #(.W(W)) u_enc_b (
        .phase(eval_phase), .data(op_b), .rail_t(b_t), .rail_f(b_f)
    );
    gpk_encoder #(.W(W)) u_gpk (
        .at(a_t), .af(a_f), .bt(b_t), .bf(b_f),
        .gen(gen), .prop(prop), .kill(kill)
    );
    rail_decoder #(.W(W)) u_dec (
        .clk(clk), .rst(rst), .phase(eval_phase),
        .rail_t(res_t), .rail_f(res_f),
        .value(res_value), .valid(res_valid), .err(res_err)
    );
endmodule

// File: rtl/dualrail_codec_chk.sv
module dualrail_codec_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         eval_phase,
    input logic [W-1:0] op_a,
    input logic [W-1:0] a_t,
    input logic [W-1:0] a_f,
    input logic [W-1:0] b_t,
    input logic [W-1:0] b_f,
    input logic [W-1:0] gen,
    input logic [W-1:0] prop,
    input logic [W-1:0] kill,
    input logic [W-1:0] res_t,
    input logic [W-1:0] res_f,
    input logic [W-1:0] res_value,
    input logic         res_valid,
    input logic         res_err
);
    p_precharge_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !eval_phase |-> ((a_t | a_f | b_t | b_f) == '0));

    p_rails_complement_r2: assert property (@(posedge clk) disable iff (rst)
        eval_phase |-> (((a_t ^ a_f) == '1) && ((b_t ^ b_f) == '1) && (a_t == op_a)));

    p_gpk_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        eval_phase |-> (((gen | prop | kill) == '1) &&
                        (((gen & prop) | (gen & kill) | (prop & kill)) == '0)));

    p_gpk_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !eval_phase |-> ((gen | prop | kill) == '0));

    p_valid_needs_eval_r5: assert property (@(posedge clk) disable iff (rst)
        eval_phase && ((res_t ^ res_f) == '1) && ((res_t & res_f) == '0) |=> res_valid);

    p_value_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !res_valid && !$past(rst) |-> $stable(res_value));

    p_err_on_bad_r7: assert property (@(posedge clk) disable iff (rst)
        ((res_t & res_f) != '0) |=> res_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(res_err) |-> res_err);
endmodule

bind dualrail_codec dualrail_codec_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .eval_phase(eval_phase), .op_a(op_a),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .gen(gen), .prop(prop), .kill(kill),
    .res_t(res_t), .res_f(res_f),
    .res_value(res_value), .res_valid(res_valid), .res_err(res_err)
);

// File: tb/tb_dualrail_codec.sv
module tb_dualrail_codec;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         eval_phase = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [W-1:0] a_t, a_f, b_t, b_f, gen, prop, kill;
    logic [W-1:0] res_t = '0, res_f = '0;
    logic [W-1:0] res_value;
    logic         res_valid, res_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dualrail_codec #(.W(W)) dut (
        .clk(clk), .rst(rst), .eval_phase(eval_phase),
        .op_a(op_a), .op_b(op_b),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .gen(gen), .prop(prop), .kill(kill),
        .res_t(res_t), .res_f(res_f),
        .res_value(res_value), .res_valid(res_valid), .res_err(res_err)
    );

    typedef struct {
        logic [W-1:0] val;
        logic         vld;
        logic         err;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state built from the requirements
    logic [W-1:0] m_val = '0;
    logic         m_vld = 1'b0;
    logic         m_err = 1'b0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One clock of stimulus: drive at negedge, check combinational rails, queue registered expectation
    task automatic step(input logic r, input logic ph, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] rt, input logic [W-1:0] rf, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; eval_phase = ph; op_a = a; op_b = b; res_t = rt; res_f = rf;
        #1;
        if (ph) begin
            check("R2 a_t", a_t, a);   check("R2 a_f", a_f, ~a);
            check("R2 b_t", b_t, b);   check("R2 b_f", b_f, ~b);
            check("R3 gen", gen, a & b);
            check("R3 prop", prop, a ^ b);
            check("R3 kill", kill, ~a & ~b);
        end else begin
            check("R1 rails", a_t | a_f | b_t | b_f, '0);
            check("R4 gpk", gen | prop | kill, '0);
        end
        if (r) begin
            m_val = '0; m_vld = 1'b0; m_err = 1'b0;
        end else begin
            m_vld = ph && ((rt ^ rf) == '1);
            if (m_vld) m_val = rt;
            if (((rt & rf) != '0) || (!ph && ((rt | rf) != '0))) m_err = 1'b1;
        end
        e.val = m_val; e.vld = m_vld; e.err = m_err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: registered outputs settle after the posedge following the drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " value"}, res_value, e.val);
                check({e.tag, " valid"}, {{(W-1){1'b0}}, res_valid}, {{(W-1){1'b0}}, e.vld});
                check({e.tag, " err"},   {{(W-1){1'b0}}, res_err},   {{(W-1){1'b0}}, e.err});
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        step(1'b1, 1'b0, '0, '0, '0, '0, "R9 reset");
        step(1'b1, 1'b1, 8'hA5, 8'h3C, 8'hFF, 8'hFF, "R9 reset overrides");

        // Encoder corners
        step(1'b0, 1'b1, 8'hFF, 8'h00, 8'h0F, 8'hF0, "R5 legal");
        step(1'b0, 1'b0, 8'hFF, 8'hFF, '0, '0, "R6 precharge hold");
        step(1'b0, 1'b1, 8'h00, 8'h00, 8'hC3, 8'h3C, "R5 legal");

        // Random alternating phases with legal words
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] a, b, v;
            a = W'($urandom); b = W'($urandom); v = W'($urandom);
            step(1'b0, 1'b0, a, b, '0, '0, "R6 precharge");
            step(1'b0, 1'b1, a, b, v, ~v, "R5 evaluate");
        end

        // Incomplete word: one idle pair
        step(1'b0, 1'b1, 8'h12, 8'h34, 8'h5A, 8'h25, "R6 incomplete");
        step(1'b0, 1'b1, 8'h12, 8'h34, 8'h99, 8'h66, "R5 complete again");

        // 11 in evaluate, then clean cycles keep err
        step(1'b0, 1'b1, 8'h01, 8'h02, 8'h81, 8'h7F, "R7 bad pair eval");
        step(1'b0, 1'b0, 8'h01, 8'h02, '0, '0, "R9 sticky");
        step(1'b0, 1'b1, 8'h01, 8'h02, 8'h55, 8'hAA, "R9 sticky");
        step(1'b1, 1'b0, '0, '0, '0, '0, "R9 clear");
        step(1'b0, 1'b0, '0, '0, '0, '0, "R9 stays clear");

        // Non-idle pair during precharge
        step(1'b0, 1'b0, 8'h0F, 8'hF0, 8'h00, 8'h10, "R8 busy precharge");
        step(1'b0, 1'b1, 8'h0F, 8'hF0, 8'h33, 8'hCC, "R9 sticky");
        step(1'b1, 1'b0, '0, '0, '0, '0, "R9 clear");

        // 11 during precharge
        step(1'b0, 1'b0, 8'hAA, 8'h55, 8'h04, 8'h04, "R7 bad pair precharge");
        step(1'b0, 1'b0, '0, '0, '0, '0, "R9 sticky");
        step(1'b1, 1'b0, '0, '0, '0, '0, "R9 clear");
        step(1'b0, 1'b0, '0, '0, '0, '0, "R9 idle");

        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule